// File: doc/BRIEF.md
# NIC Command and Status Port

This block is the host-facing register window of a network controller. Software reads one word to learn which interrupts are pending, which interrupt and receive-filter enables are in force, whether the last command failed, and what state the controller is in. Software writes a second word to acknowledge interrupts, reprogram enables, or issue a command. A pair of address words holds the location of a command descriptor. An issue write copies that address into a short FIFO, which the command engine drains through a pop handshake.

Hardware event pulses from the datapath (command done, packet received, transmit done, command failed) set the matching flags. A single interrupt line combines every pending flag with its enable. Command execution itself happens outside this block. The block only queues descriptor addresses and reports the outcome.

Top module: `nic_cmd_port`

## Requirements
- R1: After synchronous reset every readable word reads zero, `irq` is low, `cmdq_valid` is low and `rx_filt_en` is zero.
- R2: Register offsets: 0 status, 1 command, 2 descriptor address low word, 3 descriptor address high word, 4 base state. Status layout:
  - bits 3:0 are the pending flags for command done, packet received, transmit done and software interrupt, in that order (bit 0 first).
  - bits 7:4 are the matching interrupt enables.
  - bits 12:8 are the receive enables for unicast, filtered multicast, broadcast, promiscuous and promiscuous multicast, in that order.
  - bit 29 is the failure flag.
  - bits 31:30 are the state code.
  - bits 28:13 read zero.
  - Writes to offset 0 have no effect.
- R3: A pulse on `ev_cmd_done`, `ev_rx_pkt` or `ev_tx_done` sets status bit 0, 1 or 2 respectively, visible the cycle after the pulse. Reading status never changes any flag.
- R4: In a command write:
  - a 1 in bits 3:0 clears the matching pending flag, and a 0 leaves it alone.
  - bits 7:4 load the interrupt enables and bits 12:8 load the receive enables, which also drive `rx_filt_en` in the same bit order.
  - an event in the same cycle as a clear leaves the flag set.
- R5: A command write with bit 7 set also sets the software pending flag (status bit 3).
- R6: `irq` is high exactly when some pending flag in status bits 3:0 has its enable in bits 7:4 set.
- R7: Reading offset 1 returns the full 32-bit word last written there.
- R8: Address handling:
  - offset 2 holds address bits 31:0 and offset 3 holds the bits above 31, up to the implemented width `ADDR_W`.
  - written bits beyond that width are discarded and read back as zero.
  - unused offsets read zero.
- R9: A command write with bit 31 set pushes the address held before that write into a `QDEPTH`-entry FIFO. `cmdq_valid` and `cmdq_addr` show the oldest entry, and a `cmdq_pop` while valid removes it. A push and a pop may occur in the same cycle.
- R10: Failure flag:
  - an issue write while the FIFO is full is dropped and sets the flag; fullness is judged before any pop in that cycle.
  - `ev_cmd_fail` also sets the flag.
  - `ev_cmd_done` without a set condition clears it.
  - the FIFO never holds more than `QDEPTH` entries.
- R11: Status bits 31:30 read 3 (busy) while the FIFO is non-empty. Otherwise they read bits 1:0 last written to offset 4, where 0 is stopped, 1 is started and 2 is initialized.
- R12: A command write with bit 31 clear never changes the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read offset |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| ev_cmd_done | input | 1 | Command completed pulse |
| ev_rx_pkt | input | 1 | Packet received pulse |
| ev_tx_done | input | 1 | Transmit completed pulse |
| ev_cmd_fail | input | 1 | Command failed pulse |
| irq | output | 1 | Interrupt request |
| cmdq_valid | output | 1 | FIFO head present |
| cmdq_pop | input | 1 | Remove FIFO head |
| cmdq_addr | output | ADDR_W | Descriptor address at the FIFO head |
| rx_filt_en | output | 5 | Receive filter enables |

## Verification
Some properties are checked on every cycle:
- event pulses leave their flag set on the following cycle.
- flags hold still when there is no command write and no event.
- a software-enable write raises and enables the software flag.
- `irq` agrees with the status flags and enables.
- undefined status bits stay zero.
- the FIFO occupancy stays within its depth.
- an issue write into a full FIFO raises the failure bit.
- the busy code appears whenever the FIFO holds an entry.

Only the bench's scenarios can show the rest, because it depends on the data that flowed in:
- FIFO ordering and the exact addresses delivered.
- the high-word truncation.
- command-word read-back.
- the set-beats-clear race.
- the base state read when the FIFO is empty.
- the fact that a clear-only write leaves the FIFO untouched.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int NUM_IRQ   = 4;
    localparam int NUM_RX    = 5;
    localparam int SW_IDX    = 3;
    localparam int PEND_LSB  = 0;
    localparam int IEN_LSB   = 4;
    localparam int RXEN_LSB  = 8;
    localparam int FAIL_BIT  = 29;
    localparam int STATE_LSB = 30;
    localparam int OP_BIT    = 31;

    localparam logic [2:0] RA_STATUS  = 3'd0;
    localparam logic [2:0] RA_CMD     = 3'd1;
    localparam logic [2:0] RA_ADDR_LO = 3'd2;
    localparam logic [2:0] RA_ADDR_HI = 3'd3;
    localparam logic [2:0] RA_BASE    = 3'd4;

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_STARTED = 2'd1,
        ST_INIT    = 2'd2,
        ST_BUSY    = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic                issue;
        logic [NUM_RX-1:0]   rx_en;
        logic [NUM_IRQ-1:0]  irq_en;
        logic [NUM_IRQ-1:0]  irq_clr;
    } cmd_word_t;

    function automatic cmd_word_t decode_cmd(input logic op, input logic [12:0] low);
        cmd_word_t c;
        c.issue   = op;
        c.irq_clr = low[3:0];
        c.irq_en  = low[7:4];
        c.rx_en   = low[12:8];
        return c;
    endfunction

    function automatic logic [31:0] pack_status(
        input logic [NUM_IRQ-1:0] pend,
        input logic [NUM_IRQ-1:0] ien,
        input logic [NUM_RX-1:0]  rxen,
        input logic               fail,
        input ctl_state_e         st
    );
        logic [31:0] s;
        s = '0;
        s[PEND_LSB +: NUM_IRQ] = pend;
        s[IEN_LSB  +: NUM_IRQ] = ien;
        s[RXEN_LSB +: NUM_RX]  = rxen;
        s[FAIL_BIT]            = fail;
        s[STATE_LSB +: 2]      = st;
        return s;
    endfunction

endpackage

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         en_we,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o,
    output logic         irq_o
);

    logic [N-1:0] pend_q;
    logic [N-1:0] en_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= en_d;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = |(pend_q & en_q);

endmodule

// File: rtl/nic_addr_latch.sv
module nic_addr_latch #(
    parameter int AW = 48
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lo_we,
    input  logic           hi_we,
    input  logic [31:0]    lo_d,
    input  logic [AW-33:0] hi_d,
    output logic [AW-1:0]  addr_o
);

    localparam int HI_W = AW - 32;

    logic [31:0]     lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= lo_d;
            if (hi_we) hi_q <= hi_d;
        end
    end

    assign addr_o = {hi_q, lo_q};

endmodule

// File: rtl/nic_cmd_fifo.sv
module nic_cmd_fifo #(
    parameter int W     = 48,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [W-1:0]               data_i,
    output logic                       valid_o,
    output logic                       full_o,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (count == CW'(DEPTH));
    assign valid_o = (count != '0);
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && valid_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= data_i;
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count;

endmodule

// File: rtl/nic_cmd_port.sv
module nic_cmd_port
    import nic_cmd_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    input  logic              ev_cmd_done,
    input  logic              ev_rx_pkt,
    input  logic              ev_tx_done,
    input  logic              ev_cmd_fail,
    output logic              irq,
    output logic              cmdq_valid,
    input  logic              cmdq_pop,
    output logic [ADDR_W-1:0] cmdq_addr,
    output logic [4:0]        rx_filt_en
);

    localparam int HI_W  = ADDR_W - 32;
    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic               cmd_wr, lo_wr, hi_wr, base_wr;
    cmd_word_t          cw;
    logic [NUM_IRQ-1:0] irq_set, irq_clr, pend, ien;
    logic [NUM_RX-1:0]  rxen_q;
    logic [31:0]        cmd_q;
    logic [1:0]         base_q;
    logic               fail_q;
    logic               push, q_full, q_valid, overflow;
    logic [CNT_W-1:0]   q_count;
    logic [ADDR_W-1:0]  cdb_addr;
    ctl_state_e         state;
    logic [31:0]        status;

    assign cmd_wr  = reg_we && (reg_waddr == RA_CMD);
    assign lo_wr   = reg_we && (reg_waddr == RA_ADDR_LO);
    assign hi_wr   = reg_we && (reg_waddr == RA_ADDR_HI);
    assign base_wr = reg_we && (reg_waddr == RA_BASE);
    assign cw      = decode_cmd(reg_wdata[OP_BIT], reg_wdata[12:0]);

    assign irq_set = {cmd_wr && cw.irq_en[SW_IDX], ev_tx_done, ev_rx_pkt, ev_cmd_done};
    assign irq_clr = cmd_wr ? cw.irq_clr : '0;

    nic_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .en_we  (cmd_wr),
        .en_d   (cw.irq_en),
        .pend_o (pend),
        .en_o   (ien),
        .irq_o  (irq)
    );

    nic_addr_latch #(.AW(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .lo_we  (lo_wr),
        .hi_we  (hi_wr),
        .lo_d   (reg_wdata),
        .hi_d   (reg_wdata[HI_W-1:0]),
        .addr_o (cdb_addr)
    );

    assign push     = cmd_wr && cw.issue;
    assign overflow = push && q_full;

    nic_cmd_fifo #(.W(ADDR_W), .DEPTH(QDEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (cmdq_pop),
        .data_i  (cdb_addr),
        .valid_o (q_valid),
        .full_o  (q_full),
        .head_o  (cmdq_addr),
        .count_o (q_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxen_q <= '0;
            cmd_q  <= '0;
            base_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                rxen_q <= cw.rx_en;
                cmd_q  <= reg_wdata;
            end
            if (base_wr) base_q <= reg_wdata[1:0];
            if (overflow || ev_cmd_fail) begin
                fail_q <= 1'b1;
            end else if (ev_cmd_done) begin
                fail_q <= 1'b0;
            end
        end
    end

    assign state  = q_valid ? ST_BUSY : ctl_state_e'(base_q);
    assign status = pack_status(pend, ien, rxen_q, fail_q, state);

    always_comb begin
        case (reg_raddr)
            RA_STATUS:  reg_rdata = status;
            RA_CMD:     reg_rdata = cmd_q;
            RA_ADDR_LO: reg_rdata = cdb_addr[31:0];
            RA_ADDR_HI: reg_rdata = 32'(cdb_addr[ADDR_W-1:32]);
            RA_BASE:    reg_rdata = {30'd0, base_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign cmdq_valid = q_valid;
    assign rx_filt_en = rxen_q;

endmodule

// File: rtl/nic_cmd_port_chk.sv
module nic_cmd_port_chk #(
    parameter int QDEPTH = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ev_cmd_done,
    input logic                        ev_rx_pkt,
    input logic                        ev_tx_done,
    input logic                        cmd_wr,
    input logic                        sw_req,
    input logic                        push,
    input logic                        q_full,
    input logic                        q_valid,
    input logic [$clog2(QDEPTH+1)-1:0] q_count,
    input logic [7:0]                  st_irq,
    input logic [15:0]                 st_undef,
    input logic                        st_fail,
    input logic [1:0]                  st_state,
    input logic                        irq
);

    localparam int CW = $clog2(QDEPTH + 1);

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ev_cmd_done |=> st_irq[0]);

    assert_rx_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ev_rx_pkt |=> st_irq[1]);

    assert_tx_sets_R3: assert property (@(posedge clk) disable iff (rst)
        ev_tx_done |=> st_irq[2]);

    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && !ev_cmd_done && !ev_rx_pkt && !ev_tx_done) |=> $stable(st_irq[3:0]));

    assert_sw_raise_R5: assert property (@(posedge clk) disable iff (rst)
        sw_req |=> (st_irq[3] && st_irq[7]));

    assert_irq_line_R6: assert property (@(posedge clk) disable iff (rst)
        irq == |(st_irq[3:0] & st_irq[7:4]));

    assert_undef_zero_R2: assert property (@(posedge clk) disable iff (rst)
        st_undef == 16'h0000);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(QDEPTH));

    assert_full_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (push && q_full) |=> st_fail);

    assert_valid_count_R9: assert property (@(posedge clk) disable iff (rst)
        q_valid == (q_count != '0));

    assert_busy_code_R11: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> (st_state == 2'b11));

endmodule

bind nic_cmd_port nic_cmd_port_chk #(.QDEPTH(QDEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_cmd_done (ev_cmd_done),
    .ev_rx_pkt   (ev_rx_pkt),
    .ev_tx_done  (ev_tx_done),
    .cmd_wr      (cmd_wr),
    .sw_req      (irq_set[3]),
    .push        (push),
    .q_full      (q_full),
    .q_valid     (q_valid),
    .q_count     (q_count),
    .st_irq      (status[7:0]),
    .st_undef    (status[28:13]),
    .st_fail     (status[29]),
    .st_state    (status[31:30]),
    .irq         (irq)
);

// File: tb/tb_nic_cmd_port.sv
module tb_nic_cmd_port;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 48;
    localparam int QD  = 4;
    localparam int HW  = AW - 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_we;
    logic [2:0]    reg_waddr;
    logic [31:0]   reg_wdata;
    logic [2:0]    reg_raddr;
    logic [31:0]   reg_rdata;
    logic          ev_cmd_done, ev_rx_pkt, ev_tx_done, ev_cmd_fail;
    logic          irq;
    logic          cmdq_valid;
    logic          cmdq_pop;
    logic [AW-1:0] cmdq_addr;
    logic [4:0]    rx_filt_en;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit finished = 0;

    // behavioural reference state
    logic [3:0]    m_pend, m_ien;
    logic [4:0]    m_rx;
    logic          m_fail;
    logic [1:0]    m_base;
    logic [31:0]   m_cmd, m_lo;
    logic [HW-1:0] m_hi;
    logic [AW-1:0] mq[$];

    nic_cmd_port #(.ADDR_W(AW), .QDEPTH(QD)) dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .ev_cmd_done(ev_cmd_done), .ev_rx_pkt(ev_rx_pkt),
        .ev_tx_done(ev_tx_done), .ev_cmd_fail(ev_cmd_fail),
        .irq(irq), .cmdq_valid(cmdq_valid), .cmdq_pop(cmdq_pop),
        .cmdq_addr(cmdq_addr), .rx_filt_en(rx_filt_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    function automatic logic [31:0] m_status();
        logic [1:0] st;
        st = (mq.size() != 0) ? 2'd3 : m_base;
        return {st, m_fail, 16'h0, m_rx, m_ien, m_pend};
    endfunction

    task automatic compare_all();
        logic [31:0] exp_rd;
        string tag;
        chk("R6 irq", irq, |(m_pend & m_ien));
        chk("R9 valid", cmdq_valid, mq.size() != 0);
        if (mq.size() != 0) chk("R9 head", cmdq_addr, mq[0]);
        chk("R4 filters", rx_filt_en, m_rx);
        case (reg_raddr)
            3'd0: begin exp_rd = m_status(); tag = "R2 status"; end
            3'd1: begin exp_rd = m_cmd; tag = "R7 cmd readback"; end
            3'd2: begin exp_rd = m_lo; tag = "R8 addr lo"; end
            3'd3: begin exp_rd = 32'(m_hi); tag = "R8 addr hi"; end
            3'd4: begin exp_rd = {30'd0, m_base}; tag = "R11 base"; end
            default: begin exp_rd = '0; tag = "R8 unused"; end
        endcase
        chk(tag, reg_rdata, exp_rd);
    endtask

    // ev: {fail, tx, rx, done}
    task automatic step(input bit we, input logic [2:0] wa, input logic [31:0] wd,
                        input logic [2:0] ra, input logic [3:0] ev, input bit pop);
        logic [3:0] np;
        logic       fset, do_push, full;
        reg_we = we; reg_waddr = wa; reg_wdata = wd; reg_raddr = ra;
        ev_cmd_done = ev[0]; ev_rx_pkt = ev[1]; ev_tx_done = ev[2]; ev_cmd_fail = ev[3];
        cmdq_pop = pop;
        np = m_pend; fset = 0; do_push = 0;
        full = (mq.size() == QD);
        if (we && wa == 3'd1) begin
            np = np & ~wd[3:0];
            m_ien = wd[7:4];
            m_rx  = wd[12:8];
            m_cmd = wd;
            if (wd[7]) np[3] = 1'b1;
            if (wd[31]) begin
                if (full) fset = 1; else do_push = 1;
            end
        end
        np[0] = np[0] | ev[0];
        np[1] = np[1] | ev[1];
        np[2] = np[2] | ev[2];
        m_pend = np;
        if (fset || ev[3]) m_fail = 1'b1;
        else if (ev[0]) m_fail = 1'b0;
        if (pop && mq.size() != 0) void'(mq.pop_front());
        if (do_push) mq.push_back({m_hi, m_lo});
        if (we && wa == 3'd2) m_lo = wd;
        if (we && wa == 3'd3) m_hi = wd[HW-1:0];
        if (we && wa == 3'd4) m_base = wd[1:0];
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic [2:0] ra);
        step(0, 3'd0, 32'h0, ra, 4'h0, 0);
    endtask

    task automatic wr(input logic [2:0] wa, input logic [31:0] wd);
        step(1, wa, wd, 3'd0, 4'h0, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                summary();
                $finish;
            end
        end
    end

    initial begin
        rst = 1; reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
        ev_cmd_done = 0; ev_rx_pkt = 0; ev_tx_done = 0; ev_cmd_fail = 0; cmdq_pop = 0;
        m_pend = 0; m_ien = 0; m_rx = 0; m_fail = 0; m_base = 0; m_cmd = 0; m_lo = 0; m_hi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state on every offset and output
        for (int a = 0; a < 8; a++) begin
            reg_raddr = 3'(a);
            #1;
            chk("R1 reset read", reg_rdata, 32'h0);
        end
        chk("R1 reset irq", irq, 0);
        chk("R1 reset valid", cmdq_valid, 0);
        chk("R1 reset filters", rx_filt_en, 0);
        idle(3'd0);

        // R3: events set flags, reads leave them set
        step(0, 0, 0, 3'd0, 4'b0010, 0);
        chk("R3 rx flag", reg_rdata[1], 1);
        repeat (3) idle(3'd0);
        chk("R3 read no side effect", reg_rdata[3:0], 4'b0010);
        step(0, 0, 0, 3'd0, 4'b0101, 0);
        chk("R3 done+tx flags", reg_rdata[3:0], 4'b0111);
        // R2: write to status offset ignored
        wr(3'd0, 32'hFFFF_FFFF);
        chk("R2 status write ignored", reg_rdata, 32'h0000_0007);

        // R6/R4: enable rx interrupt, clear, race
        wr(3'd1, 32'h0000_0020);
        chk("R6 irq raised", irq, 1);
        wr(3'd1, 32'h0000_0022);
        chk("R4 clear rx", reg_rdata[1], 0);
        chk("R4 other flags kept", reg_rdata[3:0], 4'b0101);
        chk("R6 irq low", irq, 0);
        step(1, 3'd1, 32'h0000_0022, 3'd0, 4'b0010, 0);
        chk("R4 set beats clear", reg_rdata[1], 1);

        // R5: software interrupt
        wr(3'd1, 32'h0000_0080);
        chk("R5 sw flag", reg_rdata[3], 1);
        chk("R5 irq via sw", irq, 1);
        wr(3'd1, 32'h0000_000F);
        chk("R4 clear all", reg_rdata[7:0], 8'h00);

        // R4/R7: filters and readback
        wr(3'd1, 32'h0000_1500);
        chk("R4 filter bits", rx_filt_en, 5'b10101);
        step(0, 0, 0, 3'd1, 4'h0, 0);
        chk("R7 readback", reg_rdata, 32'h0000_1500);

        // R8: address words, truncation
        wr(3'd2, 32'hDEAD_BEEF);
        wr(3'd3, 32'hFFFF_1234);
        step(0, 0, 0, 3'd3, 4'h0, 0);
        chk("R8 hi truncated", reg_rdata, 32'h0000_1234);
        step(0, 0, 0, 3'd6, 4'h0, 0);
        chk("R8 unused offset", reg_rdata, 32'h0);

        // R12: clear-only write leaves fifo alone
        wr(3'd1, 32'h0000_0000);
        chk("R12 no push", cmdq_valid, 0);

        // R9/R11: issue commands until full
        wr(3'd4, 32'h0000_0002);
        chk("R11 base state", reg_rdata[31:30], 2'd2);
        wr(3'd1, 32'h8000_0000);
        chk("R9 head addr", cmdq_addr, 48'h1234_DEAD_BEEF);
        chk("R11 busy", reg_rdata[31:30], 2'd3);
        for (int k = 1; k < QD; k++) begin
            wr(3'd2, 32'h1000_0000 + 32'(k));
            wr(3'd1, 32'h8000_0000);
        end
        wr(3'd2, 32'hAAAA_0000);
        wr(3'd1, 32'h8000_0000);
        chk("R10 overflow fail", reg_rdata[29], 1);
        // full + push + pop same cycle: pop happens, push dropped
        step(1, 3'd1, 32'h8000_0000, 3'd0, 4'h0, 1);
        chk("R10 full push dropped", cmdq_addr, 48'h1234_1000_0001);
        // push and pop together when not full
        step(1, 3'd1, 32'h8000_0000, 3'd0, 4'h0, 1);
        chk("R9 push+pop", cmdq_addr, 48'h1234_1000_0002);
        while (mq.size() != 0) step(0, 0, 0, 3'd0, 4'h0, 1);
        chk("R11 base after drain", reg_rdata[31:30], 2'd2);

        // R10: fail flag via events
        step(0, 0, 0, 3'd0, 4'b0001, 0);
        chk("R10 done clears fail", reg_rdata[29], 0);
        step(0, 0, 0, 3'd0, 4'b1001, 0);
        chk("R10 fail wins", reg_rdata[29], 1);

        // mixed traffic against the reference model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            logic [2:0]  wa;
            logic [3:0]  ev;
            d  = $urandom;
            wa = 3'($urandom % 6);
            ev = 4'($urandom) & 4'($urandom);
            step(($urandom % 3) != 0, wa, d, 3'($urandom % 6), ev, ($urandom % 3) == 0);
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule